// File: doc/BRIEF.md
# Spread Spectrum Triangle Modulator

This block generates the digital frequency-offset profile used to spread the energy of a synthesized clock. On every reference tick it moves a signed offset word by a fixed step along a linear triangle. The PLL adds that word to its nominal feedback divide ratio, so the output frequency sweeps up and down around, or just below, its target. The PLL, oscillator, loop filter and divider quantiser lie outside this block.

Two spread shapes are supported. Centre spread swings the offset equally above and below zero, so the average frequency equals the target. Down spread keeps the highest point of the sweep at zero offset, so the peak frequency equals the target and every other point lies below it. A 5-bit amplitude code sets the total deviation in steps of one eighth of a percent, and each shape has its own legal range. A rate select chooses between the slow modulation rate (around 30 kHz) and the fast one (around 120 kHz).

A period starts at minimum frequency, rises to maximum and falls back. Shape, amplitude and rate are taken in only when a new period starts, so the sweep never jumps part-way through. A strobe marks each return to the minimum, and a direction flag shows which half of the period is running.

Top module: `ssm_triangle_mod`

## Requirements
- R1: While reset is asserted, and after it is released with enable low, offset_o is 0, dir_up_o is 1 and period_start_o is 0.
- R2: With enable_i low at a clock edge, offset_o is 0 after that edge. The first edge with enable_i high restarts the sweep at its minimum with dir_up_o = 1. Ticks are honoured from the following edge onwards.
- R3: The total deviation S is (c+1)*UNIT offset LSBs, where c is the effective amplitude code and UNIT (default 64) stands for 0.125 %. In centre mode, codes 16..31 act as 15 (at most 2.0 %). In down mode, code 0 acts as 1 (at least 0.25 %).
- R4: Centre mode (down_mode_i = 0): offset_o ranges from -S/2 at the period start up to +S/2 at the turning point.
- R5: Down mode (down_mode_i = 1): offset_o ranges from -S at the period start up to exactly 0 at the turning point, and is never positive.
- R6: After k honoured ticks into a period, offset_o = p*S/H - B. Here p = k for k <= H and p = 2H-k otherwise, B is S/2 in centre mode and S in down mode, and H is 16 ticks for rate_fast_i = 0 and 4 ticks for rate_fast_i = 1.
- R7: An edge with tick_i low leaves offset_o, dir_up_o and the period position unchanged.
- R8: dir_up_o is 1 during the first H ticks of a period and 0 during the last H ticks.
- R9: period_start_o is high for exactly one cycle, after the tick that brings the sweep back to its minimum. It is not raised when the sweep is started by enable.
- R10: Mode, amplitude code and rate are sampled only while disabled, on the first enabled edge, and on the edge that completes a period. Changes at any other time take no effect until the next period starts.
- R11: If enable_i falls on the edge that would complete a period, the disable wins: offset_o becomes 0 and no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Modulation on; low forces zero offset and rewinds the sweep |
| tick_i | input | 1 | Reference-tick enable, one step per high cycle |
| down_mode_i | input | 1 | 1 = down spread, 0 = centre spread |
| rate_fast_i | input | 1 | 1 = fast modulation rate, 0 = slow rate |
| amp_code_i | input | 5 | Amplitude code, 0.125 % per unit above one unit |
| offset_o | output | 13 | Signed offset added to the divide ratio |
| dir_up_o | output | 1 | 1 while the frequency is rising |
| period_start_o | output | 1 | One-cycle pulse on each return to minimum |

## Verification
Two functions can fall on the same edge: completing a period, which fires the strobe and reloads the configuration, and either a disable or a fresh configuration arriving on the inputs. The bench tracks the period position. It drops enable exactly on the closing tick and expects zero offset with no strobe. It also presents new mode, code and rate values exactly on the closing tick and expects the next period to follow them. Changes made mid-period are judged by checking that the old profile continues unchanged until the wrap.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int unsigned CODE_W = 5;

  typedef struct packed {
    logic              down;
    logic              fast;
    logic [CODE_W-1:0] code;
  } ssm_cfg_t;
endpackage

// File: rtl/ssm_amp_clamp.sv
module ssm_amp_clamp #(
  parameter int unsigned CODE_W = 5
) (
  input  logic              down_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] CTR_MAX = CODE_W'((1 << (CODE_W-1)) - 1);
  localparam logic [CODE_W-1:0] DN_MIN  = CODE_W'(1);

  always_comb begin
    code_o = code_i;
    if (down_i) begin
      if (code_i < DN_MIN) code_o = DN_MIN;
    end else begin
      if (code_i > CTR_MAX) code_o = CTR_MAX;
    end
  end
endmodule

// File: rtl/ssm_step_calc.sv
module ssm_step_calc #(
  parameter int unsigned CODE_W    = 5,
  parameter int unsigned UNIT      = 64,
  parameter int unsigned HALF_SLOW = 16,
  parameter int unsigned HALF_FAST = 4,
  parameter int unsigned LVL_W     = 12,
  parameter int unsigned CNT_W     = 4
) (
  input  ssm_pkg::ssm_cfg_t cfg_i,
  output logic [LVL_W-1:0]  step_o,
  output logic [LVL_W-1:0]  span_o,
  output logic [LVL_W-1:0]  base_o,
  output logic [CNT_W-1:0]  half_last_o
);
  localparam logic [LVL_W-1:0] STEP_SLOW = LVL_W'(UNIT / HALF_SLOW);
  localparam logic [LVL_W-1:0] STEP_FAST = LVL_W'(UNIT / HALF_FAST);
  localparam logic [LVL_W-1:0] UNIT_L    = LVL_W'(UNIT);

  logic [LVL_W-1:0] units;
  logic [LVL_W-1:0] step_unit;

  always_comb begin
    units  = LVL_W'(cfg_i.code) + LVL_W'(1);
    span_o = units * UNIT_L;
    base_o = cfg_i.down ? span_o : (span_o >> 1);
  end

  generate
    if (HALF_FAST == HALF_SLOW) begin : g_one_rate
      always_comb begin
        step_unit   = STEP_SLOW;
        half_last_o = CNT_W'(HALF_SLOW - 1);
      end
    end else begin : g_two_rate
      always_comb begin
        step_unit   = cfg_i.fast ? STEP_FAST : STEP_SLOW;
        half_last_o = cfg_i.fast ? CNT_W'(HALF_FAST - 1) : CNT_W'(HALF_SLOW - 1);
      end
    end
  endgenerate

  always_comb step_o = units * step_unit;
endmodule

// File: rtl/ssm_tri_core.sv
module ssm_tri_core #(
  parameter int unsigned LVL_W = 12,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             tick_i,
  input  logic [LVL_W-1:0] step_i,
  input  logic [LVL_W-1:0] span_i,
  input  logic [CNT_W-1:0] half_last_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             run_o,
  output logic             up_o,
  output logic             stb_o,
  output logic             load_o
);
  logic             run_q, run_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;
  logic             stb_q, stb_d;
  logic             load;

  always_comb begin
    run_d = enable_i;
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    up_d  = up_q;
    stb_d = 1'b0;
    load  = 1'b0;
    if (!enable_i || !run_q) begin
      lvl_d = '0;
      cnt_d = '0;
      up_d  = 1'b1;
      load  = 1'b1;
    end else if (tick_i) begin
      lvl_d = up_q ? (lvl_q + step_i) : (lvl_q - step_i);
      if (cnt_q == half_last_i) begin
        cnt_d = '0;
        up_d  = ~up_q;
        if (!up_q) begin
          stb_d = 1'b1;
          load  = 1'b1;
        end
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      lvl_q <= '0;
      cnt_q <= '0;
      up_q  <= 1'b1;
      stb_q <= 1'b0;
    end else begin
      run_q <= run_d;
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
      up_q  <= up_d;
      stb_q <= stb_d;
    end
  end

  assign lvl_o  = lvl_q;
  assign run_o  = run_q;
  assign up_o   = up_q;
  assign stb_o  = stb_q;
  assign load_o = load;

  // R4
  lvl_in_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (lvl_q <= span_i));

  // R2
  disable_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (lvl_q == '0 && up_q && !stb_q));

  // R7
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && enable_i && !tick_i) |=> ($stable(lvl_q) && $stable(up_q) && !stb_q));

  // R9
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);

  // R9
  strobe_at_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (lvl_q == '0 && up_q));
endmodule

// File: rtl/ssm_triangle_mod.sv
module ssm_triangle_mod #(
  parameter int unsigned CODE_W    = ssm_pkg::CODE_W,
  parameter int unsigned UNIT      = 64,
  parameter int unsigned HALF_SLOW = 16,
  parameter int unsigned HALF_FAST = 4,
  localparam int unsigned LVL_W    = $clog2((1 << CODE_W) * UNIT + 1),
  localparam int unsigned OFF_W    = LVL_W + 1,
  localparam int unsigned HALF_MAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST,
  localparam int unsigned CNT_W    = (HALF_MAX > 2) ? $clog2(HALF_MAX) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable_i,
  input  logic                    tick_i,
  input  logic                    down_mode_i,
  input  logic                    rate_fast_i,
  input  logic [CODE_W-1:0]       amp_code_i,
  output logic signed [OFF_W-1:0] offset_o,
  output logic                    dir_up_o,
  output logic                    period_start_o
);
  ssm_pkg::ssm_cfg_t cfg_q, cfg_d;
  logic [CODE_W-1:0] code_eff;
  logic [LVL_W-1:0]  step, span, base, lvl;
  logic [CNT_W-1:0]  half_last;
  logic              run, up, stb, load;

  ssm_amp_clamp #(.CODE_W(CODE_W)) u_clamp (
    .down_i (down_mode_i),
    .code_i (amp_code_i),
    .code_o (code_eff)
  );

  always_comb begin
    cfg_d = cfg_q;
    if (load) begin
      cfg_d.down = down_mode_i;
      cfg_d.fast = rate_fast_i;
      cfg_d.code = code_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  ssm_step_calc #(
    .CODE_W(CODE_W), .UNIT(UNIT), .HALF_SLOW(HALF_SLOW),
    .HALF_FAST(HALF_FAST), .LVL_W(LVL_W), .CNT_W(CNT_W)
  ) u_step (
    .cfg_i       (cfg_q),
    .step_o      (step),
    .span_o      (span),
    .base_o      (base),
    .half_last_o (half_last)
  );

  ssm_tri_core #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable_i),
    .tick_i      (tick_i),
    .step_i      (step),
    .span_i      (span),
    .half_last_i (half_last),
    .lvl_o       (lvl),
    .run_o       (run),
    .up_o        (up),
    .stb_o       (stb),
    .load_o      (load)
  );

  always_comb begin
    if (run) offset_o = $signed({1'b0, lvl}) - $signed({1'b0, base});
    else     offset_o = '0;
  end

  assign dir_up_o       = up;
  assign period_start_o = stb;

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));

  // R3
  down_code_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cfg_q.down) |-> (cfg_q.code != '0));

  // R5
  down_never_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cfg_q.down) |-> (offset_o <= 0));
endmodule

// File: tb/test_ssm_triangle_mod.sv
module test_ssm_triangle_mod;
  logic clk = 1'b0;
  logic rst_n;
  logic en, tick, dn, fast;
  logic [4:0] code;
  logic signed [12:0] offset;
  logic dir_up, pstart;

  always #2 clk = ~clk;

  ssm_triangle_mod i_ssm_triangle_mod (
    .clk(clk), .rst_n(rst_n), .enable_i(en), .tick_i(tick),
    .down_mode_i(dn), .rate_fast_i(fast), .amp_code_i(code),
    .offset_o(offset), .dir_up_o(dir_up), .period_start_o(pstart)
  );

  int checks = 0;
  int fails  = 0;
  int m_run = 0, m_k = 0, m_dn = 0, m_fast = 0, m_code = 0, m_stb = 0;
  int e_off, e_dir;
  int pmin, pmax;

  function automatic int clampc(int d, int c);
    if (d != 0) return (c == 0) ? 1 : c;
    return (c > 15) ? 15 : c;
  endfunction
  function automatic int m_half();
    return (m_fast != 0) ? 4 : 16;
  endfunction
  function automatic int m_span();
    return (m_code + 1) * 64;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_cfg();
    m_dn = dn; m_fast = fast; m_code = clampc(dn, code);
  endtask

  task automatic edge_chk(input string tg);
    int h, s, b, p;
    @(posedge clk);
    m_stb = 0;
    if (!en || m_run == 0) begin
      m_run = en; m_k = 0; load_cfg();
    end else if (tick) begin
      m_k++;
      if (m_k == 2 * m_half()) begin
        m_k = 0; m_stb = 1; load_cfg();
      end
    end
    #1;
    h = m_half(); s = m_span(); b = (m_dn != 0) ? s : s / 2;
    p = (m_k <= h) ? m_k : 2 * h - m_k;
    e_off = (m_run != 0) ? (p * s / h - b) : 0;
    e_dir = (m_k < h) ? 1 : 0;
    chk(offset == e_off, tg, int'(offset), e_off);
    chk(dir_up == e_dir, "R8", int'(dir_up), e_dir);
    chk(pstart == m_stb, "R9", int'(pstart), m_stb);
    if (m_run != 0 && m_k == 0)
      chk(offset == -b, (m_dn != 0) ? "R5" : "R4", int'(offset), -b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 0; tick = 0; dn = 0; fast = 0; code = 5'd3;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(offset == 0, "R1", int'(offset), 0);
    chk(dir_up == 1, "R1", int'(dir_up), 1);
    chk(pstart == 0, "R1", int'(pstart), 0);
    rst_n = 1'b1;
    edge_chk("R1");

    // Sweep every mode, rate and code through a full period (R3 R6)
    for (int d = 0; d < 2; d++)
      for (int f = 0; f < 2; f++)
        for (int c = 0; c < 32; c++) begin
          en = 0; dn = d[0]; fast = f[0]; code = c[4:0]; tick = 1;
          edge_chk("R2");
          en = 1;
          edge_chk("R6");
          pmin = offset; pmax = offset;
          for (int t = 0; t < 2 * m_half(); t++) begin
            edge_chk("R6");
            if (offset < pmin) pmin = offset;
            if (offset > pmax) pmax = offset;
          end
          chk(pmax - pmin == (clampc(d, c) + 1) * 64, "R3", pmax - pmin, (clampc(d, c) + 1) * 64);
          if (d == 1) chk(pmax == 0, "R5", pmax, 0);
          else chk(pmax == -pmin, "R4", pmax, -pmin);
        end

    // R7 sparse ticks
    en = 0; dn = 0; fast = 1; code = 5'd9; edge_chk("R2");
    en = 1;
    for (int t = 0; t < 60; t++) begin
      tick = (t % 3 == 1) ? 1'b1 : 1'b0;
      edge_chk("R7");
    end

    // R10 mid-period change ignored until wrap
    tick = 1; en = 0; dn = 1; fast = 0; code = 5'd20; edge_chk("R2");
    en = 1; edge_chk("R10");
    repeat (5) edge_chk("R10");
    dn = 0; fast = 1; code = 5'd4;
    for (int t = 0; t < 40; t++) edge_chk("R10");

    // R2 disable mid-period then restart
    repeat (3) edge_chk("R2");
    en = 0; edge_chk("R2");
    chk(offset == 0, "R2", int'(offset), 0);
    en = 1; edge_chk("R2");
    chk(dir_up == 1, "R2", int'(dir_up), 1);

    // R11 disable on the closing tick
    while (m_k != 2 * m_half() - 1) edge_chk("R6");
    en = 0; edge_chk("R11");
    chk(pstart == 0, "R11", int'(pstart), 0);
    chk(offset == 0, "R11", int'(offset), 0);

    // R10 new configuration presented on the closing tick
    en = 1; dn = 0; fast = 1; code = 5'd7; edge_chk("R10");
    while (m_k != 2 * m_half() - 1) edge_chk("R6");
    dn = 1; fast = 0; code = 5'd0;
    edge_chk("R10");
    chk(offset == -128, "R10", int'(offset), -128);
    for (int t = 0; t < 34; t++) edge_chk("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule